// File: doc/BRIEF.md
# Display Data RAM with Segment Mirroring

This block holds the pixel image for a 96-column by 68-row monochrome panel. The storage is split into 9 pages, and each page is a row of 96 column bytes. A byte covers eight pixel rows of its page. Bit 0 is the top row of the page and bit 7 is the bottom row. The last page is only half populated: only its four low bits are real pixel rows.

The host side writes through an address pointer. It loads a page and a column, then streams data bytes. The column advances by one after each byte and the page stays where it is.

The panel-refresh side fetches one byte per cycle. It addresses the byte by page and segment number. A direction input chooses how segments map to columns: either segment n reads column n, or the image is mirrored so that segment n reads column 95−n. Both sides run in the same clock cycle. When they collide on the same byte, the refresh read wins and still sees a whole, coherent byte. The write is parked in a one-entry holding slot and lands on the next cycle.

Top module: `disp_ram`

## Requirements
- R1: While reset is asserted and just after it is released, `cur_col_o` and `cur_page_o` are 0, `rd_valid_o` is 0, and every stored byte reads back as 0x00.
- R2: A byte written with `wr_en_i` is stored at the current (page, column). A refresh read of that location, issued in a later cycle, returns the byte.
- R3: Each accepted write advances the column pointer by one. A write leaves the page pointer unchanged.
- R4: The column pointer stops at 0x5F: a write at column 0x5F leaves it at 0x5F. This is the default, with `COL_WRAP`=0. Setting `COL_WRAP`=1 makes it return to 0x00 instead.
- R5: `set_page_i` loads `page_i` when it is at most 8, and `set_col_i` loads `col_i` when it is at most 0x5F. A value outside these ranges leaves the pointer unchanged. A load takes precedence over the column advance.
- R6: With `seg_rev_i`=0, a read of segment n returns column n.
- R7: With `seg_rev_i`=1, a read of segment n returns column 95−n, so segment 0 returns column 0x5F.
- R8: Toggling `seg_rev_i` only changes which column a read selects. It never alters stored bytes.
- R9: A write to page 8 keeps only bits 3:0. Reads of page 8 always return bits 7:4 as zero.
- R10: When a read and a write target the same byte in the same cycle, the read returns the previous contents. The write is not lost: it is held and committed on the next cycle. This assumes the refresh does not fetch the same byte on two consecutive cycles.
- R11: `rd_valid_o` rises exactly one cycle after `rd_en_i`, and `rd_data_o` is valid with it. A read with a page above 8 or a segment above 95 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_page_i | input | 1 | Load page pointer |
| page_i | input | 4 | Page value to load |
| set_col_i | input | 1 | Load column pointer |
| col_i | input | 7 | Column value to load |
| wr_en_i | input | 1 | Write one data byte |
| wr_data_i | input | 8 | Data byte, bit 0 = top row |
| seg_rev_i | input | 1 | 1 = mirrored segment order |
| rd_en_i | input | 1 | Refresh fetch request |
| rd_page_i | input | 4 | Refresh page |
| rd_seg_i | input | 7 | Refresh segment number |
| rd_data_o | output | 8 | Fetched byte |
| rd_valid_o | output | 1 | Fetched byte valid |
| cur_page_o | output | 4 | Current write page |
| cur_col_o | output | 7 | Current write column |

## Verification
A fetched byte and its valid flag are due one clock edge after the request. A pointer load or an advance shows on the pointer outputs right after the edge that takes it. A written byte is readable by a fetch issued in the next cycle; when the write collided with a fetch, it is readable from the cycle after that. The bench drives inputs on the falling edge and updates its behavioural model on the rising edge. It compares every output on the following falling edge. It avoids fetching one byte in two consecutive cycles, so the model's latency matches those rules.

// File: rtl/disp_ram_pkg.sv
package disp_ram_pkg;
  // valid-row mask for a page; the last page may be partially populated
  function automatic logic [7:0] page_mask(input int unsigned page,
                                           input int unsigned n_pages,
                                           input int unsigned last_rows);
    if (page == n_pages - 1) return 8'((1 << last_rows) - 1);
    return 8'hFF;
  endfunction
endpackage

// File: rtl/disp_addr_ctr.sv
module disp_addr_ctr #(
  parameter int unsigned N_COLS   = 96,
  parameter int unsigned N_PAGES  = 9,
  parameter bit          COL_WRAP = 1'b0,
  localparam int unsigned COL_W   = $clog2(N_COLS),
  localparam int unsigned PAGE_W  = $clog2(N_PAGES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_page_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              set_col_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic              adv_i,
  output logic [PAGE_W-1:0] page_o,
  output logic [COL_W-1:0]  col_o
);
  localparam logic [COL_W-1:0]  LAST_COL  = COL_W'(N_COLS - 1);
  localparam logic [PAGE_W-1:0] LAST_PAGE = PAGE_W'(N_PAGES - 1);

  logic [COL_W-1:0]  col_q, col_end_nxt;
  logic [PAGE_W-1:0] page_q;

  generate
    if (COL_WRAP) begin : g_wrap
      assign col_end_nxt = '0;
    end else begin : g_sat
      assign col_end_nxt = LAST_COL;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q  <= '0;
      page_q <= '0;
    end else begin
      if (set_col_i && col_i <= LAST_COL) col_q <= col_i;
      else if (adv_i) col_q <= (col_q == LAST_COL) ? col_end_nxt : col_q + 1'b1;
      if (set_page_i && page_i <= LAST_PAGE) page_q <= page_i;
    end
  end

  assign col_o  = col_q;
  assign page_o = page_q;

  assert_col_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_q <= LAST_COL);
  assert_col_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !set_col_i && col_q != LAST_COL) |=> col_q == $past(col_q) + 1'b1);
  assert_page_kept_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !set_page_i) |=> $stable(page_q));
  assert_page_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_q <= LAST_PAGE);
endmodule

// File: rtl/disp_seg_map.sv
module disp_seg_map #(
  parameter int unsigned N_COLS  = 96,
  parameter bit          REV_EN  = 1'b1,
  localparam int unsigned COL_W  = $clog2(N_COLS)
) (
  input  logic [COL_W-1:0] seg_i,
  input  logic             rev_i,
  output logic [COL_W-1:0] col_o,
  output logic             in_range_o
);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(N_COLS - 1);

  assign in_range_o = (seg_i <= LAST_COL);

  generate
    if (REV_EN) begin : g_mirror
      assign col_o = rev_i ? (LAST_COL - seg_i) : seg_i;
    end else begin : g_fixed
      logic unused_rev;
      assign unused_rev = rev_i;
      assign col_o = seg_i;
    end
  endgenerate
endmodule

// File: rtl/disp_wr_arb.sv
module disp_wr_arb #(
  parameter int unsigned N_COLS  = 96,
  parameter int unsigned N_PAGES = 9,
  localparam int unsigned COL_W  = $clog2(N_COLS),
  localparam int unsigned PAGE_W = $clog2(N_PAGES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [PAGE_W-1:0] wr_page_i,
  input  logic [COL_W-1:0]  wr_col_i,
  input  logic [7:0]        wr_data_i,
  input  logic              rd_act_i,
  input  logic [PAGE_W-1:0] rd_page_i,
  input  logic [COL_W-1:0]  rd_col_i,
  // port a: held write, port b: direct write (b is newer)
  output logic              a_en_o,
  output logic [PAGE_W-1:0] a_page_o,
  output logic [COL_W-1:0]  a_col_o,
  output logic [7:0]        a_data_o,
  output logic              b_en_o,
  output logic [PAGE_W-1:0] b_page_o,
  output logic [COL_W-1:0]  b_col_o,
  output logic [7:0]        b_data_o
);
  logic              hold_v_q;
  logic [PAGE_W-1:0] hold_page_q;
  logic [COL_W-1:0]  hold_col_q;
  logic [7:0]        hold_data_q;
  logic              new_hit, hold_hit;

  assign new_hit  = wr_en_i  && rd_act_i && rd_page_i == wr_page_i   && rd_col_i == wr_col_i;
  assign hold_hit = hold_v_q && rd_act_i && rd_page_i == hold_page_q && rd_col_i == hold_col_q;

  assign a_en_o   = hold_v_q && !hold_hit;
  assign a_page_o = hold_page_q;
  assign a_col_o  = hold_col_q;
  assign a_data_o = hold_data_q;
  assign b_en_o   = wr_en_i && !new_hit;
  assign b_page_o = wr_page_i;
  assign b_col_o  = wr_col_i;
  assign b_data_o = wr_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_v_q    <= 1'b0;
      hold_page_q <= '0;
      hold_col_q  <= '0;
      hold_data_q <= '0;
    end else if (new_hit) begin
      hold_v_q    <= 1'b1;
      hold_page_q <= wr_page_i;
      hold_col_q  <= wr_col_i;
      hold_data_q <= wr_data_i;
    end else if (a_en_o) begin
      hold_v_q    <= 1'b0;
    end
  end

  assert_parked_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    new_hit |=> hold_v_q && hold_page_q == $past(wr_page_i) && hold_col_q == $past(wr_col_i)
                && hold_data_q == $past(wr_data_i));
  assert_hold_drains_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_en_o && !new_hit) |=> !hold_v_q);
  assert_no_read_clobber_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_act_i && b_en_o) |-> !(b_page_o == rd_page_i && b_col_o == rd_col_i));
endmodule

// File: rtl/disp_mem.sv
module disp_mem #(
  parameter int unsigned N_COLS    = 96,
  parameter int unsigned N_PAGES   = 9,
  parameter int unsigned LAST_ROWS = 4,
  localparam int unsigned COL_W    = $clog2(N_COLS),
  localparam int unsigned PAGE_W   = $clog2(N_PAGES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a_en_i,
  input  logic [PAGE_W-1:0] a_page_i,
  input  logic [COL_W-1:0]  a_col_i,
  input  logic [7:0]        a_data_i,
  input  logic              b_en_i,
  input  logic [PAGE_W-1:0] b_page_i,
  input  logic [COL_W-1:0]  b_col_i,
  input  logic [7:0]        b_data_i,
  input  logic              rd_en_i,
  input  logic              rd_ok_i,
  input  logic [PAGE_W-1:0] rd_page_i,
  input  logic [COL_W-1:0]  rd_col_i,
  output logic [7:0]        rd_data_o,
  output logic              rd_valid_o
);
  localparam logic [PAGE_W-1:0] LAST_PAGE = PAGE_W'(N_PAGES - 1);

  logic [7:0]        mem_q [N_PAGES][N_COLS];
  logic [7:0]        rd_data_q;
  logic              rd_valid_q;
  logic [PAGE_W-1:0] rd_page_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < int'(N_PAGES); p++)
        for (int c = 0; c < int'(N_COLS); c++)
          mem_q[p][c] <= '0;
    end else begin
      if (a_en_i) mem_q[a_page_i][a_col_i] <= a_data_i;
      if (b_en_i) mem_q[b_page_i][b_col_i] <= b_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
      rd_page_q  <= '0;
    end else begin
      rd_valid_q <= rd_en_i;
      if (rd_en_i) begin
        rd_page_q <= rd_page_i;
        rd_data_q <= rd_ok_i
          ? (mem_q[rd_page_i][rd_col_i]
             & disp_ram_pkg::page_mask(int'(rd_page_i), N_PAGES, LAST_ROWS))
          : 8'h00;
      end
    end
  end

  assign rd_data_o  = rd_data_q;
  assign rd_valid_o = rd_valid_q;

  assert_last_page_upper_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_q && rd_page_q == LAST_PAGE) |-> (rd_data_q >> LAST_ROWS) == 8'h00);
endmodule

// File: rtl/disp_ram.sv
module disp_ram #(
  parameter int unsigned N_COLS    = 96,
  parameter int unsigned N_PAGES   = 9,
  parameter int unsigned LAST_ROWS = 4,
  parameter bit          COL_WRAP  = 1'b0,
  localparam int unsigned COL_W    = $clog2(N_COLS),
  localparam int unsigned PAGE_W   = $clog2(N_PAGES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_page_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              set_col_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic              wr_en_i,
  input  logic [7:0]        wr_data_i,
  input  logic              seg_rev_i,
  input  logic              rd_en_i,
  input  logic [PAGE_W-1:0] rd_page_i,
  input  logic [COL_W-1:0]  rd_seg_i,
  output logic [7:0]        rd_data_o,
  output logic              rd_valid_o,
  output logic [PAGE_W-1:0] cur_page_o,
  output logic [COL_W-1:0]  cur_col_o
);
  localparam logic [PAGE_W-1:0] LAST_PAGE = PAGE_W'(N_PAGES - 1);

  logic [PAGE_W-1:0] wr_page, a_page, b_page;
  logic [COL_W-1:0]  wr_col, rd_col, a_col, b_col;
  logic [7:0]        wr_data_m, a_data, b_data;
  logic              seg_ok, rd_ok, rd_act, a_en, b_en;

  disp_addr_ctr #(.N_COLS(N_COLS), .N_PAGES(N_PAGES), .COL_WRAP(COL_WRAP)) u_ctr (
    .clk_i, .rst_ni, .set_page_i, .page_i, .set_col_i, .col_i,
    .adv_i(wr_en_i), .page_o(wr_page), .col_o(wr_col)
  );

  disp_seg_map #(.N_COLS(N_COLS), .REV_EN(1'b1)) u_map (
    .seg_i(rd_seg_i), .rev_i(seg_rev_i), .col_o(rd_col), .in_range_o(seg_ok)
  );

  assign rd_ok     = seg_ok && rd_page_i <= LAST_PAGE;
  assign rd_act    = rd_en_i && rd_ok;
  assign wr_data_m = wr_data_i & disp_ram_pkg::page_mask(int'(wr_page), N_PAGES, LAST_ROWS);

  disp_wr_arb #(.N_COLS(N_COLS), .N_PAGES(N_PAGES)) u_arb (
    .clk_i, .rst_ni,
    .wr_en_i, .wr_page_i(wr_page), .wr_col_i(wr_col), .wr_data_i(wr_data_m),
    .rd_act_i(rd_act), .rd_page_i, .rd_col_i(rd_col),
    .a_en_o(a_en), .a_page_o(a_page), .a_col_o(a_col), .a_data_o(a_data),
    .b_en_o(b_en), .b_page_o(b_page), .b_col_o(b_col), .b_data_o(b_data)
  );

  disp_mem #(.N_COLS(N_COLS), .N_PAGES(N_PAGES), .LAST_ROWS(LAST_ROWS)) u_mem (
    .clk_i, .rst_ni,
    .a_en_i(a_en), .a_page_i(a_page), .a_col_i(a_col), .a_data_i(a_data),
    .b_en_i(b_en), .b_page_i(b_page), .b_col_i(b_col), .b_data_i(b_data),
    .rd_en_i, .rd_ok_i(rd_ok), .rd_page_i, .rd_col_i(rd_col),
    .rd_data_o, .rd_valid_o
  );

  assign cur_page_o = wr_page;
  assign cur_col_o  = wr_col;

  assert_valid_latency_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rd_valid_o);
  assert_valid_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rd_valid_o);
  assert_bad_addr_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !rd_ok) |=> rd_data_o == 8'h00);
endmodule

// File: tb/disp_ram_tb.sv
module disp_ram_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       set_page = 0, set_col = 0, wr_en = 0, seg_rev = 0, rd_en = 0;
  logic [3:0] page = 0, rd_page = 0, cur_page;
  logic [6:0] col = 0, rd_seg = 0, cur_col;
  logic [7:0] wr_data = 0, rd_data;
  logic       rd_valid;

  int checks = 0, fails = 0;
  bit done = 0, run_chk = 0;
  string tag = "R2", exp_tag = "R2";

  // behavioural reference
  int m_mem [9][96];
  int m_col = 0, m_page = 0, e_valid = 0, e_data = 0;

  always #5 clk = ~clk;

  disp_ram u_dut (
    .clk_i(clk), .rst_ni(rst_n), .set_page_i(set_page), .page_i(page),
    .set_col_i(set_col), .col_i(col), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .seg_rev_i(seg_rev), .rd_en_i(rd_en), .rd_page_i(rd_page), .rd_seg_i(rd_seg),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid), .cur_page_o(cur_page), .cur_col_o(cur_col)
  );

  function automatic int lookup(int p, int s, bit rev);
    if (p > 8 || s > 95) return 0;
    return m_mem[p][rev ? 95 - s : s];
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      e_valid = rd_en;
      if (rd_en) begin
        e_data  = lookup(int'(rd_page), int'(rd_seg), seg_rev);
        exp_tag = tag;
      end
      if (wr_en) m_mem[m_page][m_col] = (m_page == 8) ? (int'(wr_data) & 15) : int'(wr_data);
      if (set_col && col <= 95) m_col = int'(col);
      else if (wr_en) m_col = (m_col == 95) ? 95 : m_col + 1;
      if (set_page && page <= 8) m_page = int'(page);
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && run_chk) begin
      chk("R3 col", int'(cur_col), m_col);
      chk("R5 page", int'(cur_page), m_page);
      chk("R11 valid", int'(rd_valid), e_valid);
      if (e_valid != 0) chk(exp_tag, int'(rd_data), e_data);
    end
  end

  task automatic clr();
    set_page = 0; set_col = 0; wr_en = 0; rd_en = 0;
  endtask
  task automatic setpc(int p, int c);
    set_page = 1; page = 4'(p); set_col = 1; col = 7'(c);
    @(negedge clk); clr();
  endtask
  task automatic wr(int d);
    wr_en = 1; wr_data = 8'(d);
    @(negedge clk); clr();
  endtask
  task automatic rd(int p, int s);
    rd_en = 1; rd_page = 4'(p); rd_seg = 7'(s);
    @(negedge clk); clr();
  endtask
  task automatic wr_rd(int d, int p, int s);
    wr_en = 1; wr_data = 8'(d); rd_en = 1; rd_page = 4'(p); rd_seg = 7'(s);
    @(negedge clk); clr();
  endtask

  initial begin
    for (int p = 0; p < 9; p++) for (int c = 0; c < 96; c++) m_mem[p][c] = 0;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 col", int'(cur_col), 0);
    chk("R1 page", int'(cur_page), 0);
    chk("R1 valid", int'(rd_valid), 0);
    rst_n = 1; run_chk = 1;
    @(negedge clk);
    tag = "R1"; rd(0, 0); rd(8, 95); rd(4, 50);

    // R2, R3: stream into page 2
    tag = "R2"; setpc(2, 10);
    for (int i = 0; i < 6; i++) wr(8'h30 + i * 7);
    for (int i = 0; i < 6; i++) rd(2, 10 + i);

    // R4: saturation at last column
    tag = "R4"; setpc(5, 94);
    wr(8'hA1); wr(8'hA2); wr(8'hA3); wr(8'hA4);
    rd(5, 94); rd(5, 95);

    // R5: out-of-range loads ignored, in-range loads taken
    tag = "R5"; set_col = 1; col = 7'd100; @(negedge clk); clr();
    set_page = 1; page = 4'd12; @(negedge clk); clr();
    setpc(7, 0); wr(8'h5A);
    tag = "R5"; rd(7, 0);

    // R6, R7: mirrored addressing; fill page 1 with distinct bytes
    setpc(1, 0);
    for (int i = 0; i < 96; i++) wr(i ^ 8'hC3);
    tag = "R6"; seg_rev = 0;
    rd(1, 0); rd(1, 1); rd(1, 95); rd(1, 40);
    tag = "R7"; seg_rev = 1;
    rd(1, 0); rd(1, 1); rd(1, 95); rd(1, 40);

    // R8: toggling direction does not touch contents
    tag = "R8";
    for (int k = 0; k < 4; k++) begin
      seg_rev = ~seg_rev; @(negedge clk);
    end
    seg_rev = 0;
    for (int i = 0; i < 96; i += 5) rd(1, i);

    // R9: last page keeps the low nibble only
    tag = "R9"; setpc(8, 20);
    wr(8'hFF); wr(8'hA6); wr(8'h5C);
    rd(8, 20); rd(8, 21); rd(8, 22);

    // R10: same-byte collision; read returns old, write lands after
    setpc(3, 30); seg_rev = 0;
    wr(8'h11); setpc(3, 30);
    tag = "R10"; wr_rd(8'h99, 3, 30);
    rd(3, 31);
    rd(3, 30);
    // collision in mirrored mode, next write goes straight through
    seg_rev = 1; setpc(3, 60);
    wr_rd(8'h77, 3, 35);
    wr_rd(8'h78, 3, 0);
    rd(3, 34); rd(3, 35);
    // scan and write streams crossing each other
    setpc(6, 0);
    for (int i = 0; i < 96; i++) wr_rd(8'h80 + i, 6, i);
    for (int i = 0; i < 96; i += 3) rd(6, i);
    seg_rev = 0;

    // R11: out-of-range read addresses
    tag = "R11"; rd(9, 3); rd(15, 0); rd(0, 96); rd(0, 127);
    @(negedge clk); @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule